// File: doc/BRIEF.md
# SPI Byte Queue Status and Interrupt Unit

This unit sits between the register side of an SPI controller and its serial shifter. It provides two byte queues: a send queue filled by writes to the data register and emptied by the shifter, and a receive queue filled by the shifter and emptied by reads of the data register. Each queue is 256 bytes deep.

Around the queues it builds a five-bit status word and a four-bit raw interrupt word. The raw word has a sticky receive-overrun flag, a receive-idle timeout, and two level flags, one per queue, each set against a programmable 7-bit watermark. A mask selects which raw bits reach the masked word and the single interrupt line. Software clears sticky bits through a write-one clear strobe. The shifter drives `shift_active` and gives one `sclk_tick` pulse per serial clock period. The shifter timing uses those ticks.

Top module: `spi_fifo_irq`

## Requirements
- R1: After reset, `status` reads 5'b00011, `thr_rdata` reads 16'h2020, `raw_irq` reads 4'b1000, `masked_irq` reads 0 and `irq` is low.
- R2: Bytes written with `dr_wr` come out on `tx_data` in write order, one per `tx_pop`. A write while 256 bytes are held is dropped.
- R3: Bytes pushed with `rx_push` appear on `dr_rdata` in push order, one per `dr_rd`. A read while the receive queue is empty changes nothing.
- R4: `status` bit 0 is send queue empty, bit 1 is send queue not full, bit 2 is receive queue not empty, bit 3 is receive queue full, and bit 4 is busy.
- R5: A `thr_wr` loads the send watermark from bits 6:0 and the receive watermark from bits 14:8. Bits 7 and 15 are ignored. `thr_rdata` returns both fields in the same places, with zeros elsewhere.
- R6: `raw_irq` bit 2 is 1 exactly while the receive occupancy is at or above the receive watermark.
- R7: `raw_irq` bit 3 is 1 exactly while the send occupancy is at or below the send watermark.
- R8: An `rx_push` into a full receive queue without a same-cycle read discards the byte. It sets `raw_irq` bit 0, which then stays set until an `icr_wr` with `icr_wdata` bit 0 equal to 1. If set and clear happen in the same cycle, set wins.
- R9: `raw_irq` bit 1 sets once TICKS (default 32) `sclk_tick` pulses have passed while the receive queue was non-empty with no accepted push or read. Any of these clears it and restarts the count: an accepted push, an accepted read, the queue emptying, or an `icr_wr` with `icr_wdata` bit 1 equal to 1.
- R10: `masked_irq` is `raw_irq` AND the mask loaded by `mask_wr` (reset 0). `irq` is the OR of `masked_irq`.
- R11: Busy is 1 when `shift_active` is 1, or when `enable` is 1 and the send queue holds data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enabled |
| dr_wr | input | 1 | Data register write strobe (push to send queue) |
| dr_wdata | input | 8 | Byte to send |
| dr_rd | input | 1 | Data register read strobe (pop receive queue) |
| dr_rdata | output | 8 | Head of receive queue |
| thr_wr | input | 1 | Watermark register write strobe |
| thr_wdata | input | 16 | Watermark write value |
| thr_rdata | output | 16 | Watermark register contents |
| mask_wr | input | 1 | Interrupt mask write strobe |
| mask_wdata | input | 4 | Interrupt mask value |
| icr_wr | input | 1 | Interrupt clear strobe |
| icr_wdata | input | 2 | Clear bits: 0 overrun, 1 timeout |
| tx_pop | input | 1 | Shifter takes a byte |
| tx_data | output | 8 | Head of send queue |
| rx_push | input | 1 | Shifter delivers a byte |
| rx_pdata | input | 8 | Delivered byte |
| shift_active | input | 1 | Shifter mid-transfer |
| sclk_tick | input | 1 | One pulse per serial clock period |
| status | output | 5 | Status flags |
| raw_irq | output | 4 | Raw interrupt bits |
| masked_irq | output | 4 | Raw bits AND mask |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest states to reach are the full-queue edges. Overrun needs a 257th push into a receive queue that holds exactly 256 bytes. The dropped-write case needs the same for the send queue. The bench streams 256 bytes into each queue, then one more, and drains the whole queue through the scoreboard to show the extra byte never entered. The timeout is exercised one tick short of its count and then at the count, both before and after a clear, so an off-by-one in the idle counter shows up.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int ST_TX_EMPTY    = 0;
  localparam int ST_TX_NOT_FULL = 1;
  localparam int ST_RX_NOT_EMPTY = 2;
  localparam int ST_RX_FULL     = 3;
  localparam int ST_BUSY        = 4;

  localparam int IRQ_OVERRUN = 0;
  localparam int IRQ_TIMEOUT = 1;
  localparam int IRQ_RX_LVL  = 2;
  localparam int IRQ_TX_LVL  = 3;
  localparam int IRQ_N       = 4;

  typedef struct packed {
    logic [6:0] rx;
    logic [6:0] tx;
  } wmark_t;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 256,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_n, rptr_q, rptr_n;
  logic [CW-1:0] cnt_q, cnt_n;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign pop_ok  = pop & ~empty;
  assign push_ok = push & (~full | pop_ok);
  assign rdata   = mem[rptr_q];
  assign count   = cnt_q;

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    cnt_n  = cnt_q;
    if (push_ok) wptr_n = wptr_q + 1'b1;
    if (pop_ok)  rptr_n = rptr_q + 1'b1;
    if (push_ok && !pop_ok)      cnt_n = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= wdata;
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r3_empty_pop_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> cnt_q == '0);
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int TICKS = 32,
  localparam int TW   = $clog2(TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_empty,
  input  logic activity,
  input  logic clr,
  input  logic tick,
  output logic expired
);
  logic [TW-1:0] cnt_q, cnt_n;

  assign expired = (cnt_q == TW'(TICKS));

  always_comb begin
    cnt_n = cnt_q;
    if (rx_empty || activity || clr) cnt_n = '0;
    else if (tick && !expired)       cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  a_r9_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> !rx_empty);
  a_r9_activity_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> !expired);
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_fifo_pkg::*;
#(
  parameter int CW       = 9,
  parameter int WM_RESET = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          thr_wr,
  input  logic [15:0]   thr_wdata,
  output logic [15:0]   thr_rdata,
  input  logic          mask_wr,
  input  logic [IRQ_N-1:0] mask_wdata,
  input  logic          icr_wr,
  input  logic [1:0]    icr_wdata,
  input  logic          ovr_evt,
  input  logic          to_expired,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  output logic [IRQ_N-1:0] raw,
  output logic [IRQ_N-1:0] masked,
  output logic          irq
);
  wmark_t             wm_q, wm_n;
  logic [IRQ_N-1:0]   mask_q, mask_n;
  logic               ovr_q, ovr_n;
  logic               unused_thr;

  assign unused_thr = ^{thr_wdata[15], thr_wdata[7]};

  always_comb begin
    wm_n   = wm_q;
    mask_n = mask_q;
    ovr_n  = ovr_q;
    if (thr_wr) begin
      wm_n.rx = thr_wdata[14:8];
      wm_n.tx = thr_wdata[6:0];
    end
    if (mask_wr) mask_n = mask_wdata;
    if (icr_wr && icr_wdata[0]) ovr_n = 1'b0;
    if (ovr_evt)                ovr_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wm_q   <= '{rx: 7'(WM_RESET), tx: 7'(WM_RESET)};
      mask_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      wm_q   <= wm_n;
      mask_q <= mask_n;
      ovr_q  <= ovr_n;
    end
  end

  always_comb begin
    raw              = '0;
    raw[IRQ_OVERRUN] = ovr_q;
    raw[IRQ_TIMEOUT] = to_expired;
    raw[IRQ_RX_LVL]  = (rx_count >= CW'(wm_q.rx));
    raw[IRQ_TX_LVL]  = (tx_count <= CW'(wm_q.tx));
  end

  assign masked    = raw & mask_q;
  assign irq       = |masked;
  assign thr_rdata = {1'b0, wm_q.rx, 1'b0, wm_q.tx};

  a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> raw[IRQ_OVERRUN]);
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[IRQ_OVERRUN] && !(icr_wr && icr_wdata[0])) |=> raw[IRQ_OVERRUN]);
  a_r5_thr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_wr |=> $stable(thr_rdata));
endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int TICKS    = 32,
  parameter int WM_RESET = 32,
  localparam int CW      = $clog2(DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        dr_wr,
  input  logic [7:0]  dr_wdata,
  input  logic        dr_rd,
  output logic [7:0]  dr_rdata,
  input  logic        thr_wr,
  input  logic [15:0] thr_wdata,
  output logic [15:0] thr_rdata,
  input  logic        mask_wr,
  input  logic [3:0]  mask_wdata,
  input  logic        icr_wr,
  input  logic [1:0]  icr_wdata,
  input  logic        tx_pop,
  output logic [7:0]  tx_data,
  input  logic        rx_push,
  input  logic [7:0]  rx_pdata,
  input  logic        shift_active,
  input  logic        sclk_tick,
  output logic [4:0]  status,
  output logic [3:0]  raw_irq,
  output logic [3:0]  masked_irq,
  output logic        irq
);
  logic          rst_meta_q, rst_sync_q;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic          to_expired, rx_activity, ovr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  byte_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_sync_q),
    .push(dr_wr), .wdata(dr_wdata), .pop(tx_pop), .rdata(tx_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok));

  byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_sync_q),
    .push(rx_push), .wdata(rx_pdata), .pop(dr_rd), .rdata(dr_rdata),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok));

  assign rx_activity = rx_push_ok | rx_pop_ok;
  assign ovr_evt     = rx_push & ~rx_push_ok;

  rx_idle_timer #(.TICKS(TICKS)) u_timer (
    .clk(clk), .rst_n(rst_sync_q),
    .rx_empty(rx_empty), .activity(rx_activity),
    .clr(icr_wr & icr_wdata[1]), .tick(sclk_tick), .expired(to_expired));

  spi_irq_regs #(.CW(CW), .WM_RESET(WM_RESET)) u_regs (
    .clk(clk), .rst_n(rst_sync_q),
    .thr_wr(thr_wr), .thr_wdata(thr_wdata), .thr_rdata(thr_rdata),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .icr_wr(icr_wr), .icr_wdata(icr_wdata),
    .ovr_evt(ovr_evt), .to_expired(to_expired),
    .rx_count(rx_cnt), .tx_count(tx_cnt),
    .raw(raw_irq), .masked(masked_irq), .irq(irq));

  always_comb begin
    status                  = '0;
    status[ST_TX_EMPTY]     = tx_empty;
    status[ST_TX_NOT_FULL]  = ~tx_full;
    status[ST_RX_NOT_EMPTY] = ~rx_empty;
    status[ST_RX_FULL]      = rx_full;
    status[ST_BUSY]         = shift_active | (enable & ~tx_empty);
  end

  a_r11_busy_shift: assert property (@(posedge clk) disable iff (!rst_sync_q)
    shift_active |-> status[ST_BUSY]);
  a_r2_pop_moves_head: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (tx_pop_ok && !tx_push_ok) |=> tx_cnt == $past(tx_cnt) - 1'b1);
  a_r8_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ovr_evt |=> status[ST_RX_FULL]);
endmodule

// File: tb/spi_fifo_irq_test.sv
module spi_fifo_irq_test;
  logic        clk, rst_n, enable;
  logic        dr_wr, dr_rd, thr_wr, mask_wr, icr_wr, tx_pop, rx_push;
  logic        shift_active, sclk_tick;
  logic [7:0]  dr_wdata, rx_pdata;
  logic [15:0] thr_wdata;
  logic [3:0]  mask_wdata;
  logic [1:0]  icr_wdata;
  logic [7:0]  dr_rdata, tx_data;
  logic [15:0] thr_rdata;
  logic [4:0]  status;
  logic [3:0]  raw_irq, masked_irq;
  logic        irq;

  int total = 0;
  int bad   = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  spi_fifo_irq uut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .dr_wr(dr_wr), .dr_wdata(dr_wdata), .dr_rd(dr_rd), .dr_rdata(dr_rdata),
    .thr_wr(thr_wr), .thr_wdata(thr_wdata), .thr_rdata(thr_rdata),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .icr_wr(icr_wr), .icr_wdata(icr_wdata),
    .tx_pop(tx_pop), .tx_data(tx_data),
    .rx_push(rx_push), .rx_pdata(rx_pdata),
    .shift_active(shift_active), .sclk_tick(sclk_tick),
    .status(status), .raw_irq(raw_irq), .masked_irq(masked_irq), .irq(irq));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares queue heads while a pop is presented
  always @(negedge clk) begin
    if (rst_n && tx_pop && txq.size() > 0) begin
      chk(tx_data == txq[0], "R2 tx order", tx_data, txq[0]);
      void'(txq.pop_front());
    end
    if (rst_n && dr_rd && rxq.size() > 0) begin
      chk(dr_rdata == rxq[0], "R3 rx order", dr_rdata, rxq[0]);
      void'(rxq.pop_front());
    end
  end

  task automatic clear_strobes();
    dr_wr = 0; dr_rd = 0; thr_wr = 0; mask_wr = 0; icr_wr = 0;
    tx_pop = 0; rx_push = 0; sclk_tick = 0;
  endtask

  task automatic step();
    @(posedge clk); #2;
    clear_strobes();
  endtask

  task automatic wr_tx(input logic [7:0] b);
    dr_wr = 1; dr_wdata = b;
    if (txq.size() < 256) txq.push_back(b);
    step();
  endtask

  task automatic pop_tx();
    tx_pop = 1; step();
  endtask

  task automatic push_rx(input logic [7:0] b);
    rx_push = 1; rx_pdata = b;
    if (rxq.size() < 256) rxq.push_back(b);
    step();
  endtask

  task automatic rd_rx();
    dr_rd = 1; step();
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      sclk_tick = 1; step();
    end
  endtask

  task automatic icr(input logic [1:0] v);
    icr_wr = 1; icr_wdata = v; step();
  endtask

  task automatic set_mask(input logic [3:0] v);
    mask_wr = 1; mask_wdata = v; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; enable = 0; shift_active = 0;
    dr_wdata = 0; rx_pdata = 0; thr_wdata = 0; mask_wdata = 0; icr_wdata = 0;
    clear_strobes();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (4) @(posedge clk);
    #2;

    // R1 / R4 reset state
    chk(status == 5'b00011, "R1 status", status, 5'b00011);
    chk(thr_rdata == 16'h2020, "R1 thr", thr_rdata, 16'h2020);
    chk(raw_irq == 4'b1000, "R1 raw", raw_irq, 4'b1000);
    chk(masked_irq == 0 && irq == 0, "R1 irq", irq, 0);

    // R5 watermark layout, bits 7 and 15 ignored
    thr_wr = 1; thr_wdata = 16'h8385; step();
    chk(thr_rdata == 16'h0305, "R5 thr readback", thr_rdata, 16'h0305);

    // R2 / R7 / R11 send queue
    for (int i = 0; i < 10; i++) wr_tx(8'(8'h10 + i));
    chk(status[0] == 0, "R4 tx not empty", status[0], 0);
    chk(raw_irq[3] == 0, "R7 tx above wm", raw_irq[3], 0);
    chk(status[4] == 0, "R11 idle disabled", status[4], 0);
    enable = 1; #1;
    chk(status[4] == 1, "R11 busy enabled data", status[4], 1);
    for (int i = 0; i < 4; i++) pop_tx();
    chk(raw_irq[3] == 0, "R7 six left", raw_irq[3], 0);
    pop_tx();
    chk(raw_irq[3] == 1, "R7 five left", raw_irq[3], 1);
    for (int i = 0; i < 5; i++) pop_tx();
    chk(status[0] == 1 && status[4] == 0, "R11 drained not busy", status, 5'b00011);

    // R2 full send queue drops writes
    for (int i = 0; i < 260; i++) wr_tx(8'(i * 7));
    chk(status[1] == 0, "R4 tx full", status[1], 0);
    chk(txq.size() == 256, "R2 model depth", txq.size(), 256);
    for (int i = 0; i < 256; i++) pop_tx();
    chk(status[0] == 1 && txq.size() == 0, "R2 drained", status[0], 1);
    enable = 0;

    // R6 / R3 receive queue, watermark 3
    push_rx(8'hA1); push_rx(8'hA2);
    chk(raw_irq[2] == 0, "R6 below wm", raw_irq[2], 0);
    push_rx(8'hA3);
    chk(raw_irq[2] == 1, "R6 at wm", raw_irq[2], 1);
    chk(status[2] == 1, "R4 rx not empty", status[2], 1);
    rd_rx();
    chk(raw_irq[2] == 0, "R6 after read", raw_irq[2], 0);
    rd_rx(); rd_rx();
    chk(status[2] == 0, "R4 rx empty", status[2], 0);
    rd_rx();
    chk(status[2] == 0, "R3 empty read noop", status[2], 0);
    push_rx(8'h5A);
    chk(dr_rdata == 8'h5A, "R3 head after empty read", dr_rdata, 8'h5A);
    rd_rx();

    // R8 overrun
    for (int i = 0; i < 256; i++) push_rx(8'(i));
    chk(status[3] == 1, "R4 rx full", status[3], 1);
    chk(raw_irq[0] == 0, "R8 no overrun yet", raw_irq[0], 0);
    push_rx(8'hEE);
    chk(raw_irq[0] == 1, "R8 overrun set", raw_irq[0], 1);
    for (int i = 0; i < 256; i++) rd_rx();
    chk(status[2] == 0 && rxq.size() == 0, "R8 dropped byte absent", status[2], 0);
    chk(raw_irq[0] == 1, "R8 sticky", raw_irq[0], 1);
    icr(2'b10);
    chk(raw_irq[0] == 1, "R8 other clear bit", raw_irq[0], 1);
    icr(2'b01);
    chk(raw_irq[0] == 0, "R8 cleared", raw_irq[0], 0);

    // R9 timeout
    push_rx(8'h77);
    tick_n(31);
    chk(raw_irq[1] == 0, "R9 one short", raw_irq[1], 0);
    tick_n(1);
    chk(raw_irq[1] == 1, "R9 expired", raw_irq[1], 1);
    icr(2'b10);
    chk(raw_irq[1] == 0, "R9 cleared", raw_irq[1], 0);
    tick_n(32);
    chk(raw_irq[1] == 1, "R9 expired again", raw_irq[1], 1);

    // R10 mask
    set_mask(4'b0010);
    chk(masked_irq == 4'b0010 && irq == 1, "R10 timeout masked in", masked_irq, 4'b0010);
    set_mask(4'b0000);
    chk(irq == 0 && masked_irq == 0, "R10 masked out", irq, 0);
    rd_rx();
    chk(raw_irq[1] == 0, "R9 read clears", raw_irq[1], 0);
    set_mask(4'b1000);
    chk(irq == 1 && masked_irq == 4'b1000, "R10 tx level", masked_irq, 4'b1000);
    set_mask(4'b0000);

    // R11 shifter active
    shift_active = 1; #1;
    chk(status[4] == 1, "R11 shift active", status[4], 1);
    shift_active = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule